// File: doc/BRIEF.md
# Flash Command Sequencer

This block is the command front end of a parallel flash device. Bus write cycles carry command codes in the low byte of a 32-bit data word. The block decodes them into a read-mode select and a status register. It also drives start, suspend and resume strobes toward a separate program/erase engine, which answers with a done pulse and a fail flag. Single-write commands change the read mode or clear errors. Two-write commands start a program, start a block erase, or load a 16-bit burst configuration word. Erase and configuration each require a confirm code on the second write.

Once a program or erase is accepted, reads switch to the status register by themselves. They stay there until a read-array command is given after the engine finishes. A running operation can be parked and resumed. Program and erase each have their own parked state and their own status flag. The read data output returns the identification codes in signature mode and the status byte in status mode. Array contents and query tables are served elsewhere.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After reset the read mode is array (mode_o = 0), stat_o = 0x80, bcfg_o = 0, and no strobe is high.
- R2: In the idle state a write with low byte FFh selects array read (mode 0), 90h selects signature read (mode 1), 98h selects query read (mode 2) and 70h selects status read (mode 3). The new mode is visible in the cycle after the write edge.
- R3: In signature mode, rd_data shows 0x20 when rd_word is 0, and the device code when rd_word is 1. The device code is 0x8836 when TOP_BOOT = 1 and 0x8835 when TOP_BOOT = 0. rd_data is registered and lags its inputs by one clock.
- R4: A write of 40h followed by any write makes start_o high for exactly one cycle. With it, op_erase_o = 0, op_addr_o = the second write's address and op_data_o = the second write's data.
- R5: A write of 20h followed by a write with low byte D0h starts an erase: start_o pulses once, op_erase_o = 1 and op_addr_o = the block address. Any other second code starts nothing and sets stat_o bits 5 and 4.
- R6: Accepting a program or erase forces status read mode. Writes other than B0h and 70h are ignored while the engine runs. The mode stays at status after completion until FFh is written.
- R7: B0h during a running operation pulses susp_o and parks it. stat_o bit 2 is set for a parked program and bit 6 for a parked erase, and bit 7 reads 1. D0h while parked pulses resume_o, clears the parked bit and returns bit 7 to 0.
- R8: 60h followed by a write with low byte 03h loads bcfg_o from wr_addr[15:0] and selects array read. Any other second code sets stat_o bits 5 and 4 and leaves bcfg_o unchanged.
- R9: stat_o bit 7 is 0 from the start strobe until eng_done. If eng_fail is high with eng_done, bit 4 is set for a program and bit 5 for an erase.
- R10: Error bits 5, 4 and 1 stay set through any command until a write of 50h in the idle state clears them.
- R11: When blk_locked is high on the second write of a program or erase, start_o stays low. Bit 1 is set, together with bit 4 for a program or bit 5 for an erase.
- R12: In the idle state, writes of codes not listed above (including D0h and B0h) change neither the mode, the status nor any strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data; low byte is the command code |
| blk_locked | input | 1 | Addressed block is write-protected |
| eng_done | input | 1 | Engine completion pulse |
| eng_fail | input | 1 | Engine failure, valid with eng_done |
| rd_word | input | 1 | Signature word select (0 maker, 1 device) |
| mode_o | output | 2 | Read mode: 0 array, 1 signature, 2 query, 3 status |
| stat_o | output | 8 | Status: 7 ready, 6 erase parked, 5 erase error, 4 program error, 2 program parked, 1 lock error |
| rd_data | output | DATA_W | Registered signature or status read data |
| start_o | output | 1 | Engine start strobe |
| susp_o | output | 1 | Engine suspend strobe |
| resume_o | output | 1 | Engine resume strobe |
| op_erase_o | output | 1 | Operation type: 1 erase, 0 program |
| op_addr_o | output | ADDR_W | Latched operation address |
| op_data_o | output | DATA_W | Latched program data |
| bcfg_o | output | 16 | Burst configuration word |

## Verification
A sequencer left in a setup state shows at the ports on the next write. A harmless command then starts the engine or raises a command error instead of changing the mode, so the misplacement surfaces one cycle after that write. A parked or running state that is wrong shows at once in stat_o bits 7, 6 and 2, and in whether D0h produces a resume strobe. Lost or stuck error flags show on the status byte after completion and after a 50h write.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;
  typedef enum logic [1:0] {
    RM_ARRAY = 2'd0,
    RM_SIG   = 2'd1,
    RM_CFI   = 2'd2,
    RM_STAT  = 2'd3
  } rmode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_PG_SET, S_ER_SET, S_CFG_SET,
    S_PG_RUN, S_ER_RUN, S_PG_HOLD, S_ER_HOLD
  } cstate_e;

  localparam logic [7:0] C_READ   = 8'hFF;
  localparam logic [7:0] C_SIG    = 8'h90;
  localparam logic [7:0] C_CFI    = 8'h98;
  localparam logic [7:0] C_STAT   = 8'h70;
  localparam logic [7:0] C_CLR    = 8'h50;
  localparam logic [7:0] C_PROG   = 8'h40;
  localparam logic [7:0] C_ERASE  = 8'h20;
  localparam logic [7:0] C_CONF   = 8'hD0;
  localparam logic [7:0] C_SUSP   = 8'hB0;
  localparam logic [7:0] C_CFG    = 8'h60;
  localparam logic [7:0] C_CFG_OK = 8'h03;

  localparam int STAT_W = 8;

  typedef struct packed {
    logic pfail;
    logic efail;
    logic lock;
    logic clr;
  } err_ev_t;
endpackage

// File: rtl/fcmd_ctrl.sv
module fcmd_ctrl
  import fcmd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 32,
  parameter int BCFG_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              blk_locked,
  input  logic              eng_done,
  input  logic              eng_fail,
  output rmode_e            mode,
  output logic              start,
  output logic              susp,
  output logic              resume,
  output logic              op_erase,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic [BCFG_W-1:0] bcfg,
  output err_ev_t           ev,
  output logic              busy,
  output logic              psus,
  output logic              esus
);
  cstate_e    state;
  logic [7:0] code;

  assign code = wr_data[7:0];
  assign busy = (state == S_PG_RUN) || (state == S_ER_RUN);
  assign psus = (state == S_PG_HOLD);
  assign esus = (state == S_ER_HOLD);

  // error events seen by the status register in the same edge as the state move
  always_comb begin
    ev = '0;
    if (wr_en) begin
      case (state)
        S_IDLE:    ev.clr = (code == C_CLR);
        S_PG_SET:  if (blk_locked) begin ev.pfail = 1'b1; ev.lock = 1'b1; end
        S_ER_SET: begin
          if (code != C_CONF) begin
            ev.pfail = 1'b1;
            ev.efail = 1'b1;
          end else if (blk_locked) begin
            ev.efail = 1'b1;
            ev.lock  = 1'b1;
          end
        end
        S_CFG_SET: if (code != C_CFG_OK) begin ev.pfail = 1'b1; ev.efail = 1'b1; end
        default: ;
      endcase
    end
    if (eng_done && eng_fail) begin
      if (state == S_PG_RUN) ev.pfail = 1'b1;
      if (state == S_ER_RUN) ev.efail = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      mode     <= RM_ARRAY;
      start    <= 1'b0;
      susp     <= 1'b0;
      resume   <= 1'b0;
      op_erase <= 1'b0;
      op_addr  <= '0;
      op_data  <= '0;
      bcfg     <= '0;
    end else begin
      start  <= 1'b0;
      susp   <= 1'b0;
      resume <= 1'b0;
      case (state)
        S_IDLE: if (wr_en) begin
          case (code)
            C_READ:  mode  <= RM_ARRAY;
            C_SIG:   mode  <= RM_SIG;
            C_CFI:   mode  <= RM_CFI;
            C_STAT:  mode  <= RM_STAT;
            C_PROG:  state <= S_PG_SET;
            C_ERASE: state <= S_ER_SET;
            C_CFG:   state <= S_CFG_SET;
            default: ;
          endcase
        end
        S_PG_SET: if (wr_en) begin
          mode  <= RM_STAT;
          state <= S_IDLE;
          if (!blk_locked) begin
            start    <= 1'b1;
            op_erase <= 1'b0;
            op_addr  <= wr_addr;
            op_data  <= wr_data;
            state    <= S_PG_RUN;
          end
        end
        S_ER_SET: if (wr_en) begin
          mode  <= RM_STAT;
          state <= S_IDLE;
          if (code == C_CONF && !blk_locked) begin
            start    <= 1'b1;
            op_erase <= 1'b1;
            op_addr  <= wr_addr;
            state    <= S_ER_RUN;
          end
        end
        S_CFG_SET: if (wr_en) begin
          state <= S_IDLE;
          if (code == C_CFG_OK) begin
            bcfg <= wr_addr[BCFG_W-1:0];
            mode <= RM_ARRAY;
          end else begin
            mode <= RM_STAT;
          end
        end
        S_PG_RUN, S_ER_RUN: begin
          if (eng_done) begin
            state <= S_IDLE;
          end else if (wr_en) begin
            if (code == C_SUSP) begin
              susp  <= 1'b1;
              state <= (state == S_PG_RUN) ? S_PG_HOLD : S_ER_HOLD;
            end else if (code == C_STAT) begin
              mode <= RM_STAT;
            end
          end
        end
        S_PG_HOLD, S_ER_HOLD: if (wr_en) begin
          case (code)
            C_CONF: begin
              resume <= 1'b1;
              mode   <= RM_STAT;
              state  <= (state == S_PG_HOLD) ? S_PG_RUN : S_ER_RUN;
            end
            C_READ:  mode <= RM_ARRAY;
            C_SIG:   mode <= RM_SIG;
            C_CFI:   mode <= RM_CFI;
            C_STAT:  mode <= RM_STAT;
            default: ;
          endcase
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fcmd_status.sv
module fcmd_status
  import fcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  err_ev_t           ev,
  input  logic              busy,
  input  logic              psus,
  input  logic              esus,
  output logic [STAT_W-1:0] stat
);
  logic perr, eerr, lerr;

  always_ff @(posedge clk) begin
    if (rst) begin
      perr <= 1'b0;
      eerr <= 1'b0;
      lerr <= 1'b0;
    end else if (ev.clr) begin
      perr <= 1'b0;
      eerr <= 1'b0;
      lerr <= 1'b0;
    end else begin
      perr <= perr | ev.pfail;
      eerr <= eerr | ev.efail;
      lerr <= lerr | ev.lock;
    end
  end

  assign stat = {~busy, esus, eerr, perr, 1'b0, psus, lerr, 1'b0};
endmodule

// File: rtl/fcmd_readout.sv
module fcmd_readout
  import fcmd_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter bit TOP_BOOT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  rmode_e            mode,
  input  logic              rd_word,
  input  logic [STAT_W-1:0] stat,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [15:0] MAKER_ID = 16'h0020;
  localparam logic [15:0] DEV_ID   = TOP_BOOT ? 16'h8836 : 16'h8835;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (mode)
        RM_SIG:  rd_data <= DATA_W'(rd_word ? DEV_ID : MAKER_ID);
        RM_STAT: rd_data <= DATA_W'(stat);
        default: rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import fcmd_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 32,
  parameter int BCFG_W   = 16,
  parameter bit TOP_BOOT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              blk_locked,
  input  logic              eng_done,
  input  logic              eng_fail,
  input  logic              rd_word,
  output logic [1:0]        mode_o,
  output logic [STAT_W-1:0] stat_o,
  output logic [DATA_W-1:0] rd_data,
  output logic              start_o,
  output logic              susp_o,
  output logic              resume_o,
  output logic              op_erase_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o,
  output logic [BCFG_W-1:0] bcfg_o
);
  rmode_e  mode;
  err_ev_t ev;
  logic    busy, psus, esus;

  fcmd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BCFG_W(BCFG_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .blk_locked(blk_locked), .eng_done(eng_done), .eng_fail(eng_fail),
    .mode(mode), .start(start_o), .susp(susp_o), .resume(resume_o),
    .op_erase(op_erase_o), .op_addr(op_addr_o), .op_data(op_data_o),
    .bcfg(bcfg_o), .ev(ev), .busy(busy), .psus(psus), .esus(esus)
  );

  fcmd_status u_stat (
    .clk(clk), .rst(rst), .ev(ev), .busy(busy), .psus(psus), .esus(esus),
    .stat(stat_o)
  );

  fcmd_readout #(.DATA_W(DATA_W), .TOP_BOOT(TOP_BOOT)) u_rd (
    .clk(clk), .rst(rst), .mode(mode), .rd_word(rd_word), .stat(stat_o),
    .rd_data(rd_data)
  );

  assign mode_o = mode;
endmodule

// File: rtl/fcmd_chk.sv
module fcmd_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [1:0]        mode_o,
  input logic [7:0]        stat_o,
  input logic              start_o,
  input logic              susp_o,
  input logic              resume_o
);
  p_start_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);

  p_start_status_r6: assert property (@(posedge clk) disable iff (rst)
    start_o |-> (mode_o == 2'd3) && !stat_o[7]);

  p_parked_ready_r7: assert property (@(posedge clk) disable iff (rst)
    (stat_o[2] || stat_o[6]) |-> (stat_o[7] && !(stat_o[2] && stat_o[6])));

  p_susp_from_run_r7: assert property (@(posedge clk) disable iff (rst)
    susp_o |-> ($past(!stat_o[7]) && stat_o[7]));

  p_resume_run_r7: assert property (@(posedge clk) disable iff (rst)
    resume_o |-> !stat_o[7]);

  p_perr_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (stat_o[4] && !(wr_en && wr_data[7:0] == 8'h50)) |=> stat_o[4]);

  p_eerr_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (stat_o[5] && !(wr_en && wr_data[7:0] == 8'h50)) |=> stat_o[5]);
endmodule

bind flash_cmd_fsm fcmd_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .mode_o(mode_o),
  .stat_o(stat_o), .start_o(start_o), .susp_o(susp_o), .resume_o(resume_o)
);

// File: tb/flash_cmd_fsm_tb.sv
`timescale 1ns/1ps
module flash_cmd_fsm_tb;
  localparam int ADDR_W = 19;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              blk_locked = 1'b0;
  logic              eng_done = 1'b0;
  logic              eng_fail = 1'b0;
  logic              rd_word = 1'b0;
  logic [1:0]        mode_o;
  logic [7:0]        stat_o;
  logic [DATA_W-1:0] rd_data;
  logic              start_o, susp_o, resume_o, op_erase_o;
  logic [ADDR_W-1:0] op_addr_o;
  logic [DATA_W-1:0] op_data_o;
  logic [15:0]       bcfg_o;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  flash_cmd_fsm u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .blk_locked(blk_locked), .eng_done(eng_done), .eng_fail(eng_fail),
    .rd_word(rd_word), .mode_o(mode_o), .stat_o(stat_o), .rd_data(rd_data),
    .start_o(start_o), .susp_o(susp_o), .resume_o(resume_o),
    .op_erase_o(op_erase_o), .op_addr_o(op_addr_o), .op_data_o(op_data_o),
    .bcfg_o(bcfg_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus write; returns at the falling edge after the sampling edge
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // countdown engine model: wait, then one done pulse
  task automatic run_engine(input int cycles, input logic fail);
    repeat (cycles) @(negedge clk);
    eng_done = 1'b1; eng_fail = fail;
    @(negedge clk);
    eng_done = 1'b0; eng_fail = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 mode", mode_o, 2'd0);
    check("R1 stat", stat_o, 8'h80);
    check("R1 bcfg", bcfg_o, 16'h0);
    check("R1 strobes", {start_o, susp_o, resume_o}, 3'b000);
  endtask

  task automatic t_modes;
    wr(0, 32'h90); check("R2 sig", mode_o, 2'd1);
    wr(0, 32'h98); check("R2 cfi", mode_o, 2'd2);
    wr(0, 32'h70); check("R2 stat", mode_o, 2'd3);
    wr(0, 32'hFF); check("R2 array", mode_o, 2'd0);
    wr(0, 32'h90);
    wr(0, 32'h33); check("R12 mode kept", mode_o, 2'd1);
    wr(0, 32'hD0); check("R12 stat kept", stat_o, 8'h80);
    wr(0, 32'hB0);
    check("R12 no strobe", {start_o, susp_o, resume_o}, 3'b000);
    check("R12 mode after B0", mode_o, 2'd1);
    wr(0, 32'hFF);
  endtask

  task automatic t_signature;
    wr(0, 32'h90);
    rd_word = 1'b0; @(negedge clk);
    check("R3 maker", rd_data, 32'h20);
    rd_word = 1'b1; @(negedge clk);
    check("R3 device", rd_data, 32'h8836);
    wr(0, 32'hFF); @(negedge clk);
    check("R3 array read zero", rd_data, 32'h0);
  endtask

  task automatic t_program;
    wr(0, 32'h40);
    check("R4 no start on setup", start_o, 1'b0);
    wr(19'h12345, 32'hCAFE0001);
    check("R4 start", start_o, 1'b1);
    check("R4 op type", op_erase_o, 1'b0);
    check("R4 addr", op_addr_o, 19'h12345);
    check("R4 data", op_data_o, 32'hCAFE0001);
    check("R6 status mode", mode_o, 2'd3);
    check("R9 busy", stat_o, 8'h00);
    @(negedge clk);
    check("R4 one cycle", start_o, 1'b0);
    check("R6 status read", rd_data, 32'h0);
    wr(0, 32'hFF); check("R6 FF ignored while running", mode_o, 2'd3);
    run_engine(5, 1'b0);
    check("R9 ready", stat_o, 8'h80);
    check("R6 still status", mode_o, 2'd3);
    @(negedge clk);
    check("R6 status readout", rd_data, 32'h80);
    wr(0, 32'hFF); check("R6 back to array", mode_o, 2'd0);
  endtask

  task automatic t_erase;
    wr(0, 32'h20);
    wr(19'h4C000, 32'hD0);
    check("R5 start", start_o, 1'b1);
    check("R5 op type", op_erase_o, 1'b1);
    check("R5 addr", op_addr_o, 19'h4C000);
    run_engine(8, 1'b0);
    check("R5 done ok", stat_o, 8'h80);
    wr(0, 32'hFF);
    wr(0, 32'h20);
    wr(19'h4C000, 32'h77);
    check("R5 bad confirm no start", start_o, 1'b0);
    check("R5 cmd error", stat_o, 8'hB0);
    wr(0, 32'h50);
    check("R10 clear", stat_o, 8'h80);
    wr(0, 32'hFF);
  endtask

  task automatic t_suspend;
    wr(0, 32'h40); wr(19'h100, 32'h5);
    wr(0, 32'hB0);
    check("R7 susp strobe", susp_o, 1'b1);
    check("R7 program parked", stat_o, 8'h84);
    wr(0, 32'hD0);
    check("R7 resume strobe", resume_o, 1'b1);
    check("R7 running again", stat_o, 8'h00);
    run_engine(3, 1'b0);
    check("R7 program done", stat_o, 8'h80);
    wr(0, 32'h20); wr(19'h8000, 32'hD0);
    wr(0, 32'hB0);
    check("R7 erase parked", stat_o, 8'hC0);
    wr(0, 32'hFF);
    check("R7 array while parked", mode_o, 2'd0);
    wr(0, 32'hD0);
    check("R7 erase resumed", stat_o, 8'h00);
    check("R7 resume status mode", mode_o, 2'd3);
    run_engine(3, 1'b0);
    check("R7 erase done", stat_o, 8'h80);
    wr(0, 32'hFF);
  endtask

  task automatic t_config;
    wr(0, 32'h60);
    wr(19'h5A5A5, 32'h03);
    check("R8 bcfg", bcfg_o, 16'hA5A5);
    check("R8 array mode", mode_o, 2'd0);
    wr(0, 32'h60);
    wr(19'h01234, 32'h11);
    check("R8 bad confirm keeps bcfg", bcfg_o, 16'hA5A5);
    check("R8 bad confirm error", stat_o, 8'hB0);
    wr(0, 32'h50); wr(0, 32'hFF);
  endtask

  task automatic t_fail_sticky;
    wr(0, 32'h40); wr(19'h200, 32'h1);
    run_engine(4, 1'b1);
    check("R9 program fail bit", stat_o, 8'h90);
    wr(0, 32'hFF); wr(0, 32'h90); wr(0, 32'h70);
    check("R10 error sticky", stat_o, 8'h90);
    wr(0, 32'h50);
    check("R10 cleared", stat_o, 8'h80);
    wr(0, 32'h20); wr(19'h0, 32'hD0);
    run_engine(4, 1'b1);
    check("R9 erase fail bit", stat_o, 8'hA0);
    wr(0, 32'h50); wr(0, 32'hFF);
  endtask

  task automatic t_locked;
    blk_locked = 1'b1;
    wr(0, 32'h40); wr(19'h300, 32'h9);
    check("R11 program no start", start_o, 1'b0);
    check("R11 program lock error", stat_o, 8'h92);
    check("R11 status mode", mode_o, 2'd3);
    wr(0, 32'h50);
    wr(0, 32'h20); wr(19'h300, 32'hD0);
    check("R11 erase no start", start_o, 1'b0);
    check("R11 erase lock error", stat_o, 8'hA2);
    blk_locked = 1'b0;
    wr(0, 32'h50);
    check("R10 lock bit cleared", stat_o, 8'h80);
    wr(0, 32'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_modes;
    t_signature;
    t_program;
    t_erase;
    t_suspend;
    t_config;
    t_fail_sticky;
    t_locked;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule